// File: doc/BRIEF.md
# Background Memory CRC Scanner

The scanner reads a programmed region of memory word by word while the rest of the system runs. Each word it fetches is folded into a 32-bit CRC accumulator. When the last word of the region has been accepted, the block pulses a completion event. In golden-compare mode it also compares the final CRC against a stored reference and flags a mismatch.

Software sets the block up through a small write port with a select field and 32-bit data. A registered read port returns the configuration, the run status, the running CRC and the current fetch address. A keyed write to the control register starts a scan. A keyed value in the halt field pauses fetching without losing progress.

Memory errors are detected outside the block. The memory returns correctable and uncorrectable error flags alongside each read, and the scanner turns them into separate one-cycle events.

Top module: `mem_crc_scanner`

## Requirements
- R1: A write to select 0 (control) with data bits [3:0] equal to 0xA starts a scan, and `busy` is high from the next cycle. A write to select 0 with any other value in bits [3:0] has no effect.
- R2: The setup register (select 2) holds the region size minus one in bits [9:0], counted in 256-byte units of 64 words. A scan fetches exactly units×64 words at byte addresses base, base+4, base+8 and so on. The base comes from select 1. Sizes from 1 to 1024 units are supported.
- R3: In CRC mode (setup bits [19:16] = 0x5), `scan_done` pulses for one cycle, one cycle after the last word is accepted. `crc_fail` pulses in that same cycle when the final CRC differs from the golden value (select 4) as it stood at scan start.
- R4: In scrub mode (setup bits [19:16] = 0xA), `scan_done` still pulses, but `crc_fail` never asserts, whatever the golden value is.
- R5: `busy` and bit 31 of the control readback are 1 while a scan is active and 0 when idle. `mem_req` is asserted only while busy.
- R6: With setup bits [27:24] = 0xA the scan is paused. `mem_req` drops, and the fetch address and partial CRC hold. Clearing the field resumes from the same address, and the final CRC is unchanged.
- R7: A start issued while a scan is running abandons that scan. The new scan restarts at the base with the seed reloaded, and only the new scan signals completion.
- R8: A read accepted with `mem_cerr` set pulses `corr_err` one cycle later. A read accepted with `mem_uerr` set pulses `uncorr_err` one cycle later. The two events are independent.
- R9: The read port returns the running CRC at select 5 and the fetch address at select 6, one cycle after `rd_sel` is applied.
- R10: The accumulator is loaded from the seed (select 3) at start. Each word is folded in MSB first with polynomial 0x04C11DB7, without reflection and with no final XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for writes |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Registered read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the current fetch |
| mem_ack | input | 1 | Read accepted, data valid |
| mem_rdata | input | 32 | Read data |
| mem_cerr | input | 1 | Correctable error on this read |
| mem_uerr | input | 1 | Uncorrectable error on this read |
| busy | output | 1 | Scan active |
| crc_value | output | 32 | Running CRC |
| scan_done | output | 1 | Completion pulse |
| crc_fail | output | 1 | Golden mismatch pulse |
| corr_err | output | 1 | Correctable error event |
| uncorr_err | output | 1 | Uncorrectable error event |

## Verification
The assertions check several rules on every cycle:
- requests only while busy
- a 4-byte address step on each accepted word
- address and CRC held when no word is accepted
- completion and error pulses only after an accepted read
- a mismatch flag only together with completion

Other properties can only be shown by the bench's scenarios:
- the CRC value itself
- the exact word count for a given size, including the largest size
- scrub mode suppressing the compare
- an identical result across a pause
- a restart discarding the earlier scan

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam logic [3:0]  KEY_GO     = 4'hA;
  localparam logic [3:0]  KEY_HALT   = 4'hA;
  localparam logic [3:0]  MODE_CRC   = 4'h5;
  localparam logic [3:0]  MODE_SCRUB = 4'hA;
  localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_SETUP  = 3'd2,
    SEL_SEED   = 3'd3,
    SEL_GOLD   = 3'd4,
    SEL_RESULT = 3'd5,
    SEL_ADDR   = 3'd6
  } reg_sel_e;

  // One 32-bit word folded in, most significant bit first.
  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs
  import mcs_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  output logic              go,
  output logic              halted,
  output logic [AW-1:0]     base,
  output logic [SIZE_W-1:0] size_m1,
  output logic [3:0]        mode,
  output logic [3:0]        halt_key,
  output logic [31:0]       seed,
  output logic [31:0]       golden
);

  assign go     = we && (sel == SEL_CTRL) && (wdata[3:0] == KEY_GO);
  assign halted = (halt_key == KEY_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      size_m1  <= '0;
      mode     <= MODE_SCRUB;
      halt_key <= '0;
      seed     <= '0;
      golden   <= '0;
    end else if (we) begin
      case (sel)
        SEL_BASE: base <= wdata[AW-1:0];
        SEL_SETUP: begin
          size_m1  <= wdata[SIZE_W-1:0];
          mode     <= wdata[19:16];
          halt_key <= wdata[27:24];
        end
        SEL_SEED: seed   <= wdata;
        SEL_GOLD: golden <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mcs_walker.sv
module mcs_walker #(
  parameter int AW         = 32,
  parameter int SIZE_W     = 10,
  parameter int UNIT_WORDS = 64,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              halted,
  input  logic              mem_ack,
  input  logic [AW-1:0]     base,
  input  logic [SIZE_W-1:0] size_m1,
  output logic              busy,
  output logic              mem_req,
  output logic [AW-1:0]     cur_addr,
  output logic              accept,
  output logic              last_word
);

  localparam int UNIT_SH = $clog2(UNIT_WORDS);
  localparam int CW      = SIZE_W + UNIT_SH + 1;

  logic [CW-1:0] remain;
  logic [CW-1:0] units;

  assign units     = CW'(size_m1) + CW'(1);
  assign mem_req   = busy && !halted;
  assign accept    = mem_req && mem_ack && !go;
  assign last_word = accept && (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      cur_addr <= base;
      remain   <= units << UNIT_SH;
    end else if (accept) begin
      cur_addr <= cur_addr + AW'(WORD_BYTES);
      remain   <= remain - CW'(1);
      if (last_word) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/mcs_crc_acc.sv
module mcs_crc_acc
  import mcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic [31:0] seed,
  input  logic [31:0] golden,
  input  logic [3:0]  mode,
  input  logic        accept,
  input  logic        last_word,
  input  logic [31:0] rdata,
  input  logic        cerr,
  input  logic        uerr,
  output logic [31:0] crc,
  output logic        done,
  output logic        fail,
  output logic        corr,
  output logic        uncorr
);

  logic [31:0] gold_q;
  logic [3:0]  mode_q;
  logic [31:0] crc_nxt;

  assign crc_nxt = crc_fold(crc, rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc    <= '0;
      gold_q <= '0;
      mode_q <= MODE_SCRUB;
      done   <= 1'b0;
      fail   <= 1'b0;
      corr   <= 1'b0;
      uncorr <= 1'b0;
    end else begin
      done   <= last_word;
      fail   <= last_word && (mode_q == MODE_CRC) && (crc_nxt != gold_q);
      corr   <= accept && cerr;
      uncorr <= accept && uerr;
      if (go) begin
        crc    <= seed;
        gold_q <= golden;
        mode_q <= mode;
      end else if (accept) begin
        crc <= crc_nxt;
      end
    end
  end

endmodule

// File: rtl/mem_crc_scanner.sv
module mem_crc_scanner
  import mcs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SIZE_W     = 10,
  parameter int UNIT_WORDS = 64,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_cerr,
  input  logic          mem_uerr,
  output logic          busy,
  output logic [31:0]   crc_value,
  output logic          scan_done,
  output logic          crc_fail,
  output logic          corr_err,
  output logic          uncorr_err
);

  localparam int PAD_W = 16 - SIZE_W;

  logic              go, halted, accept, last_word;
  logic [AW-1:0]     base;
  logic [SIZE_W-1:0] size_m1;
  logic [3:0]        mode, halt_key;
  logic [31:0]       seed, golden;

  mcs_cfg_regs #(.AW(AW), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .go(go), .halted(halted), .base(base), .size_m1(size_m1), .mode(mode),
    .halt_key(halt_key), .seed(seed), .golden(golden)
  );

  mcs_walker #(.AW(AW), .SIZE_W(SIZE_W), .UNIT_WORDS(UNIT_WORDS), .WORD_BYTES(WORD_BYTES)) u_walk (
    .clk(clk), .rst(rst), .go(go), .halted(halted), .mem_ack(mem_ack),
    .base(base), .size_m1(size_m1), .busy(busy), .mem_req(mem_req),
    .cur_addr(mem_addr), .accept(accept), .last_word(last_word)
  );

  mcs_crc_acc u_acc (
    .clk(clk), .rst(rst), .go(go), .seed(seed), .golden(golden), .mode(mode),
    .accept(accept), .last_word(last_word), .rdata(mem_rdata),
    .cerr(mem_cerr), .uerr(mem_uerr), .crc(crc_value), .done(scan_done),
    .fail(crc_fail), .corr(corr_err), .uncorr(uncorr_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_CTRL:   rd_data <= {busy, 31'b0};
        SEL_BASE:   rd_data <= 32'(base);
        SEL_SETUP:  rd_data <= {4'b0, halt_key, 4'b0, mode, {PAD_W{1'b0}}, size_m1};
        SEL_SEED:   rd_data <= seed;
        SEL_GOLD:   rd_data <= golden;
        SEL_RESULT: rd_data <= crc_value;
        SEL_ADDR:   rd_data <= 32'(mem_addr);
        default:    rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [31:0]   cfg_wdata,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic [31:0]   crc_value,
  input logic          scan_done,
  input logic          crc_fail,
  input logic          corr_err,
  input logic          uncorr_err
);

  logic start_wr;
  assign start_wr = cfg_we && (cfg_sel == 3'd0) && (cfg_wdata[3:0] == 4'hA);

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !start_wr) |=> (mem_addr == $past(mem_addr) + AW'(4))); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!(mem_req && mem_ack) && !start_wr) |=> ($stable(mem_addr) && $stable(crc_value))); // R6

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> $past(mem_req && mem_ack)); // R3

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    crc_fail |-> scan_done); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> !busy); // R1

  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (corr_err || uncorr_err) |-> $past(mem_req && mem_ack)); // R8

endmodule

bind mem_crc_scanner mcs_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .busy(busy),
  .crc_value(crc_value), .scan_done(scan_done), .crc_fail(crc_fail),
  .corr_err(corr_err), .uncorr_err(uncorr_err)
);

// File: tb/test_mem_crc_scanner.sv
module test_mem_crc_scanner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_cerr = 1'b0;
  logic        mem_uerr = 1'b0;
  logic        busy, scan_done, crc_fail, corr_err, uncorr_err;
  logic [31:0] crc_value;

  int errors = 0, checks = 0, cycles = 0;
  int words_seen = 0, corr_seen = 0, uncorr_seen = 0, tick = 0;
  bit ack_always = 1'b0;
  logic [31:0] cerr_at = 32'hFFFF_FFFF, uerr_at = 32'hFFFF_FFFF;

  typedef struct { logic [31:0] crc; logic fail; logic [31:0] end_addr; string tag; } exp_t;
  exp_t sb[$];

  mem_crc_scanner i_mem_crc_scanner (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_cerr(mem_cerr), .mem_uerr(mem_uerr),
    .busy(busy), .crc_value(crc_value), .scan_done(scan_done), .crc_fail(crc_fail),
    .corr_err(corr_err), .uncorr_err(uncorr_err)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A_0000;
  endfunction

  // R10: seed, poly 0x04C11DB7, MSB first, no reflection, no final XOR
  function automatic logic [31:0] ref_crc(input logic [31:0] seed, input logic [31:0] base, input int words);
    logic [31:0] r;
    r = seed;
    for (int w = 0; w < words; w++) begin
      r = r ^ word_at(base + 32'(w * 4));
      for (int b = 0; b < 32; b++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: acks decided away from the edge
  always @(negedge clk) begin
    tick++;
    if (mem_req && (ack_always || (tick % 3 != 1))) begin
      mem_ack   = 1'b1;
      mem_rdata = word_at(mem_addr);
      mem_cerr  = (mem_addr == cerr_at);
      mem_uerr  = (mem_addr == uerr_at);
    end else begin
      mem_ack = 1'b0; mem_cerr = 1'b0; mem_uerr = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst && mem_req && mem_ack) words_seen++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (corr_err) corr_seen++;
      if (uncorr_err) uncorr_seen++;
      if (scan_done) begin
        if (sb.size() == 0) check(1'b0, "R7 unexpected completion", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(crc_value == e.crc, {e.tag, " crc"}, crc_value, e.crc);
          check(crc_fail == e.fail, {e.tag, " fail flag"}, 32'(crc_fail), 32'(e.fail));
          check(mem_addr == e.end_addr, {e.tag, " end address"}, mem_addr, e.end_addr);
        end
      end else if (crc_fail) check(1'b0, "R3 fail without done", 32'd1, 32'd0);
    end
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); rd_sel = s;
    @(negedge clk); d = rd_data;
  endtask

  function automatic logic [31:0] setup_word(input int units, input logic [3:0] mode, input logic [3:0] hk);
    return (32'(hk) << 24) | (32'(mode) << 16) | 32'(units - 1);
  endfunction

  // driver: program region and push the expected outcome
  task automatic prog_and_expect(input logic [31:0] base, input int units, input logic [3:0] mode,
                                 input logic [31:0] seed, input bit good_gold, input string tag);
    logic [31:0] c;
    exp_t e;
    c = ref_crc(seed, base, units * 64);
    wr(3'd1, base);
    wr(3'd2, setup_word(units, mode, 4'h0));
    wr(3'd3, seed);
    wr(3'd4, good_gold ? c : ~c);
    e.crc = c; e.fail = (mode == 4'h5) && !good_gold; e.end_addr = base + 32'(units * 256); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, a0, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_req && !scan_done, "R5 reset idle", {busy, mem_req, scan_done}, 32'd0);
    rd(3'd0, v);
    check(v[31] == 1'b0, "R5 status bit idle", v, 32'd0);

    // R1: wrong key does nothing
    wr(3'd0, 32'h5);
    repeat (3) @(negedge clk);
    check(!busy && !mem_req, "R1 wrong key ignored", 32'(busy), 32'd0);

    // R3/R10: CRC mode, good golden, single unit
    prog_and_expect(32'h0000_1000, 1, 4'h5, 32'hFFFF_FFFF, 1'b1, "R3 match");
    words_seen = 0;
    wr(3'd0, 32'hA);
    check(busy, "R1 busy after start", 32'(busy), 32'd1);
    rd(3'd0, v);
    check(v[31] == 1'b1, "R5 status bit active", v, 32'h8000_0000);
    wait_idle();
    check(words_seen == 64, "R2 one unit word count", 32'(words_seen), 32'd64);
    rd(3'd5, v);
    check(v == ref_crc(32'hFFFF_FFFF, 32'h1000, 64), "R9 result readback", v, ref_crc(32'hFFFF_FFFF, 32'h1000, 64));
    rd(3'd6, v);
    check(v == 32'h1100, "R9 address readback", v, 32'h1100);

    // R3: mismatch in CRC mode
    prog_and_expect(32'h0002_0000, 2, 4'h5, 32'h1234_5678, 1'b0, "R3 mismatch");
    words_seen = 0;
    wr(3'd0, 32'hA);
    wait_idle();
    check(words_seen == 128, "R2 two unit word count", 32'(words_seen), 32'd128);

    // R4: scrub mode never fails
    prog_and_expect(32'h0003_0000, 1, 4'hA, 32'h0, 1'b0, "R4 scrub");
    wr(3'd0, 32'hA);
    wait_idle();

    // R6: halt and resume
    prog_and_expect(32'h0004_0000, 2, 4'h5, 32'hCAFE_F00D, 1'b1, "R6 resume");
    wr(3'd0, 32'hA);
    repeat (30) @(negedge clk);
    wr(3'd2, setup_word(2, 4'h5, 4'hA));
    @(negedge clk);
    a0 = mem_addr; c0 = crc_value;
    repeat (20) @(negedge clk);
    check(!mem_req && busy, "R6 no request while halted", 32'(mem_req), 32'd0);
    check(mem_addr == a0, "R6 address held", mem_addr, a0);
    check(crc_value == c0, "R6 partial crc held", crc_value, c0);
    wr(3'd2, setup_word(2, 4'h5, 4'h0));
    wait_idle();

    // R7: restart mid-scan with a new seed
    wr(3'd1, 32'h0005_0000);
    wr(3'd2, setup_word(2, 4'h5, 4'h0));
    wr(3'd0, 32'hA);
    repeat (40) @(negedge clk);
    prog_and_expect(32'h0006_0000, 1, 4'h5, 32'h0BAD_BEEF, 1'b1, "R7 restart");
    wr(3'd0, 32'hA);
    wait_idle();
    check(sb.size() == 0, "R7 single completion", 32'(sb.size()), 32'd0);

    // R8: error indications
    corr_seen = 0; uncorr_seen = 0;
    cerr_at = 32'h0007_0008; uerr_at = 32'h0007_0014;
    prog_and_expect(32'h0007_0000, 1, 4'hA, 32'h0, 1'b1, "R8 scan");
    wr(3'd0, 32'hA);
    wait_idle();
    check(corr_seen == 1, "R8 correctable events", 32'(corr_seen), 32'd1);
    check(uncorr_seen == 1, "R8 uncorrectable events", 32'(uncorr_seen), 32'd1);
    cerr_at = 32'hFFFF_FFFF; uerr_at = 32'hFFFF_FFFF;

    // R2: largest region, 1024 units
    ack_always = 1'b1;
    prog_and_expect(32'h0010_0000, 1024, 4'h5, 32'hFFFF_FFFF, 1'b1, "R2 max size");
    words_seen = 0;
    wr(3'd0, 32'hA);
    wait_idle();
    check(words_seen == 65536, "R2 max word count", 32'(words_seen), 32'd65536);
    check(sb.size() == 0, "R3 all completions seen", 32'(sb.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule